// File: doc/BRIEF.md
# Dual-Edge Input Capture Timer

This block timestamps both edges of one external digital input against a free-running 16-bit counter that advances on every system clock. A falling edge stores the counter in one capture register and a rising edge stores it in a second one. Software can therefore measure the width of either level or the full period of a signal by subtracting stamps. The input passes through a two-flop synchroniser, and edges are found by comparing the synchronised level with its value one clock earlier.

Each edge kind sets its own event flag. A counter wrap sets a third flag. A single interrupt line is the OR of the flags whose enable bits are set. Software clears flags by writing ones to the status register. When an edge overwrites a capture that software has not yet read, a per-register overrun bit is set. Access goes through a small word-addressed read/write port. Reads are combinational, and a read strobe on a capture address marks that register as read.

Register addresses: 0 falling capture, 1 rising capture, 2 interrupt enables, 3 status, 4 live counter. Bit positions in the enable and status words: bit 0 falling, bit 1 rising, bit 2 wrap. The status word also holds bit 3 falling overrun and bit 4 rising overrun.

Top module: `edge_capture_timer`

## Requirements
- R1: The counter is 16 bits wide, is 0 after reset, increases by one on every clock and rolls over from 0xFFFF to 0x0000; address 4 returns its current value.
- R2: When the input goes from 1 to 0 between clock edges k-1 and k, the register at address 0 is loaded at edge k+2 with the counter value held just before that edge.
- R3: A 0 to 1 change of the input loads the register at address 1 with the same timing rule as R2.
- R4: The capture register and its event flag (status bit 0 falling, bit 1 rising) are updated no more than 4 clocks after the input change, and the interrupt follows no more than 4 clocks after it.
- R5: The interrupt output is high exactly when some status bit 0..2 is set and the enable bit at the same position of address 2 is set; with all enables clear it stays low while flags are set.
- R6: Writing address 3 clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R7: The clock on which the counter rolls over from 0xFFFF sets status bit 2.
- R8: An edge whose capture register has not been read since its last load overwrites it and sets its overrun bit (status bit 3 falling, bit 4 rising); a read strobe on the capture address marks the register as read.
- R9: After reset the capture registers, the enables and the status are 0 and the interrupt is low.
- R10: An input held low for 4 clocks and then high yields both captures, each with the R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | 1 | External capture input, asynchronous, idles high |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe, marks a capture register as read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register, combinational |
| irq | output | 1 | Interrupt request, OR of enabled flags |

## Verification
Edges are driven with level times that vary from long to the 4-clock minimum. The varied times make a capture that is off by one clock, or that latches the wrong edge kind, show up as a stamp mismatch rather than as a lucky hit. Runs with interrupts enabled measure the delay from input change to interrupt. Runs with interrupts disabled show that the flags still set while the line stays quiet. Two same-kind edges without a read separate overwrite-with-overrun from a plain capture. A falling edge timed just before the counter rolls over checks the rollover flag and the wrapped stamp together.

// File: rtl/ect_pkg.sv
package ect_pkg;
   localparam int unsigned REG_AW = 3;

   localparam logic [REG_AW-1:0] ADR_CAP_FALL = 3'd0;
   localparam logic [REG_AW-1:0] ADR_CAP_RISE = 3'd1;
   localparam logic [REG_AW-1:0] ADR_IRQ_EN   = 3'd2;
   localparam logic [REG_AW-1:0] ADR_STATUS   = 3'd3;
   localparam logic [REG_AW-1:0] ADR_COUNT    = 3'd4;

   localparam int unsigned BIT_EV_FALL  = 0;
   localparam int unsigned BIT_EV_RISE  = 1;
   localparam int unsigned BIT_EV_WRAP  = 2;
   localparam int unsigned BIT_OVR_BASE = 3;
   localparam int unsigned STATUS_W     = 5;
   localparam int unsigned N_CHAN       = 2;

   typedef enum logic {
      CH_FALL = 1'b0,
      CH_RISE = 1'b1
   } chan_e;
endpackage

// File: rtl/ect_sync.sv
module ect_sync #(
   parameter int unsigned STAGES     = 2,
   parameter logic        IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic fell,
   output logic rose
);
   logic [STAGES-1:0] stage_q;
   logic              prev_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= IDLE_LEVEL;
               else        stage_q[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= IDLE_LEVEL;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_LEVEL;
      else        prev_q <= stage_q[STAGES-1];
   end

   assign fell = prev_q & ~stage_q[STAGES-1];
   assign rose = ~prev_q & stage_q[STAGES-1];
endmodule

// File: rtl/ect_counter.sv
module ect_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] count,
   output logic             at_top
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= count + 1'b1;
   end

   assign at_top = (count == TOP);
endmodule

// File: rtl/ect_capture_ch.sv
module ect_capture_ch #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic [CNT_W-1:0] count,
   input  logic             rd_ack,
   input  logic             clr_flag,
   input  logic             clr_ovr,
   output logic [CNT_W-1:0] stamp,
   output logic             flag,
   output logic             ovr
);
   logic unread_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stamp    <= '0;
         unread_q <= 1'b0;
         flag     <= 1'b0;
         ovr      <= 1'b0;
      end else begin
         if (hit) stamp <= count;
         unread_q <= hit ? 1'b1 : (rd_ack ? 1'b0 : unread_q);
         flag     <= hit ? 1'b1 : (clr_flag ? 1'b0 : flag);
         ovr      <= (hit && unread_q) ? 1'b1 : (clr_ovr ? 1'b0 : ovr);
      end
   end
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
   import ect_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_in,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int unsigned N_EV = N_CHAN + 1;

   generate
      if (SYNC_STAGES < 2 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must be 2 or 3 to meet the capture latency");
      end
      if (DATA_W < CNT_W || DATA_W < STATUS_W) begin : g_bad_data
         $error("DATA_W must hold a full counter value and the status word");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
   endgenerate

   logic                          edge_fall, edge_rise;
   logic [CNT_W-1:0]              cnt_q;
   logic                          cnt_top;
   logic [N_CHAN-1:0]             ch_hit, ch_rd, ch_clr_f, ch_clr_o, ch_flag, ch_ovr;
   logic [N_CHAN-1:0][CNT_W-1:0]  ch_stamp;
   logic [N_EV-1:0]               ie_q;
   logic                          wrap_flag;
   logic                          stat_wr;
   logic [STATUS_W-1:0]           status;

   ect_sync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (cap_in),
      .fell (edge_fall),
      .rose (edge_rise)
   );

   ect_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .count (cnt_q),
      .at_top(cnt_top)
   );

   assign stat_wr = bus_wr && (bus_addr == ADR_STATUS);
   assign ch_hit  = {edge_rise, edge_fall};

   generate
      for (genvar c = 0; c < N_CHAN; c++) begin : g_ch
         localparam logic [REG_AW-1:0] MY_ADR =
            (chan_e'(c) == CH_RISE) ? ADR_CAP_RISE : ADR_CAP_FALL;
         assign ch_rd[c]    = bus_rd && (bus_addr == MY_ADR);
         assign ch_clr_f[c] = stat_wr && bus_wdata[BIT_EV_FALL + c];
         assign ch_clr_o[c] = stat_wr && bus_wdata[BIT_OVR_BASE + c];
         ect_capture_ch #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (ch_hit[c]),
            .count   (cnt_q),
            .rd_ack  (ch_rd[c]),
            .clr_flag(ch_clr_f[c]),
            .clr_ovr (ch_clr_o[c]),
            .stamp   (ch_stamp[c]),
            .flag    (ch_flag[c]),
            .ovr     (ch_ovr[c])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q      <= '0;
         wrap_flag <= 1'b0;
      end else begin
         if (bus_wr && bus_addr == ADR_IRQ_EN) ie_q <= bus_wdata[N_EV-1:0];
         if (cnt_top)                                wrap_flag <= 1'b1;
         else if (stat_wr && bus_wdata[BIT_EV_WRAP]) wrap_flag <= 1'b0;
      end
   end

   assign status = {ch_ovr[1], ch_ovr[0], wrap_flag, ch_flag[1], ch_flag[0]};
   assign irq    = |(status[N_EV-1:0] & ie_q);

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADR_CAP_FALL: bus_rdata[CNT_W-1:0]    = ch_stamp[CH_FALL];
         ADR_CAP_RISE: bus_rdata[CNT_W-1:0]    = ch_stamp[CH_RISE];
         ADR_IRQ_EN:   bus_rdata[N_EV-1:0]     = ie_q;
         ADR_STATUS:   bus_rdata[STATUS_W-1:0] = status;
         ADR_COUNT:    bus_rdata[CNT_W-1:0]    = cnt_q;
         default:      bus_rdata               = '0;
      endcase
   end
endmodule

// File: rtl/ect_checker.sv
module ect_checker #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CNT_W-1:0]  cnt,
   input logic              fell,
   input logic              rose,
   input logic [1:0]        flag,
   input logic [CNT_W-1:0]  cap_f,
   input logic [CNT_W-1:0]  cap_r,
   input logic              wrap_flag,
   input logic [2:0]        ie,
   input logic              irq,
   input logic              stat_wr,
   input logic [DATA_W-1:0] wdata
);
   // R1
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> cnt == $past(cnt) + 1'b1);

   // R2
   cap_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fell |=> cap_f == $past(cnt));

   // R3
   cap_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rose |=> cap_r == $past(cnt));

   // R4
   flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fell |=> flag[0]);

   // R4
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rose |=> flag[1]);

   // R5
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ie == 3'b000) |-> !irq);

   // R6
   w1c_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && wdata[0] && !fell) |=> !flag[0]);

   // R7
   wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == {CNT_W{1'b1}}) |=> wrap_flag);
endmodule

bind edge_capture_timer ect_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt      (cnt_q),
   .fell     (edge_fall),
   .rose     (edge_rise),
   .flag     (ch_flag),
   .cap_f    (ch_stamp[0]),
   .cap_r    (ch_stamp[1]),
   .wrap_flag(wrap_flag),
   .ie       (ie_q),
   .irq      (irq),
   .stat_wr  (stat_wr),
   .wdata    (bus_wdata)
);

// File: tb/sim_edge_capture_timer.sv
module sim_edge_capture_timer;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        rise;
      logic [15:0] val;
      logic [15:0] stamp;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cap_in = 1'b1;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq;

   int          n_checks = 0;
   int          n_fail = 0;
   logic [15:0] mcnt = '0;
   bit          mon_on = 1'b0;
   bit          done = 1'b0;
   exp_t        sb_q[$];

   edge_capture_timer u0 (
      .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference cycle counter from R1
   always @(posedge clk) begin
      if (!rst_n) mcnt <= '0;
      else        mcnt <= mcnt + 16'd1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a;
      bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a;
      bus_wdata = d;
      bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // driver: change the input and push the expected capture
   task automatic drive_edge(input logic lvl, input int hold, output logic [15:0] stamp);
      exp_t e;
      @(negedge clk);
      cap_in = lvl;
      stamp = mcnt;
      e.rise = lvl;
      e.val = 16'(mcnt + 16'd2);
      e.stamp = mcnt;
      if (mon_on) sb_q.push_back(e);
      repeat (hold) @(negedge clk);
   endtask

   // monitor: services interrupts and compares against the queue
   initial begin : monitor
      exp_t        e;
      logic [15:0] d;
      logic [15:0] lat;
      forever begin
         @(negedge clk);
         if (mon_on && sb_q.size() > 0 && irq) begin
            e = sb_q.pop_front();
            lat = mcnt - e.stamp;
            chk("R4 irq latency <= 4", {31'd0, lat <= 16'd4}, 32'd1);
            bus_read(3'd3, d);
            chk(e.rise ? "R4 rise flag" : "R4 fall flag", {31'd0, d[e.rise ? 1 : 0]}, 32'd1);
            bus_read(e.rise ? 3'd1 : 3'd0, d);
            chk(e.rise ? "R3 rise stamp" : "R2 fall stamp", {16'd0, d}, {16'd0, e.val});
            bus_write(3'd3, e.rise ? 16'h0002 : 16'h0001);
            #1 chk("R6 irq low after clear", {31'd0, irq}, 32'd0);
         end
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] d, s1, s2, s3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9 reset state
      #1 chk("R9 irq after reset", {31'd0, irq}, 32'd0);
      bus_read(3'd0, d); chk("R9 fall cap reset", {16'd0, d}, 32'd0);
      bus_read(3'd1, d); chk("R9 rise cap reset", {16'd0, d}, 32'd0);
      bus_read(3'd2, d); chk("R9 enables reset", {16'd0, d}, 32'd0);
      bus_read(3'd3, d); chk("R9 status reset", {16'd0, d}, 32'd0);
      @(negedge clk);
      bus_addr = 3'd4;
      #1 chk("R1 live counter", {16'd0, bus_rdata}, {16'd0, mcnt});

      // scoreboard run with both edge interrupts enabled
      bus_write(3'd2, 16'h0003);
      mon_on = 1'b1;
      drive_edge(1'b0, 20, s1);
      drive_edge(1'b1, 37, s1);
      drive_edge(1'b0, 16, s1);
      drive_edge(1'b1, 50, s1);
      drive_edge(1'b0, 25, s1);
      drive_edge(1'b1, 18, s1);
      while (sb_q.size() > 0) @(negedge clk);
      repeat (4) @(negedge clk);
      mon_on = 1'b0;

      // R5 flags set but interrupts disabled
      bus_write(3'd2, 16'h0000);
      drive_edge(1'b0, 6, s1);
      #1 chk("R5 irq masked", {31'd0, irq}, 32'd0);
      drive_edge(1'b1, 6, s2);
      bus_read(3'd3, d); chk("R5 both flags set", {16'd0, d}, 32'h3);
      bus_write(3'd3, 16'h0001);
      bus_read(3'd3, d); chk("R6 only written bit cleared", {16'd0, d}, 32'h2);
      bus_read(3'd0, d); chk("R2 fall stamp directed", {16'd0, d}, {16'd0, 16'(s1 + 16'd2)});
      bus_read(3'd1, d); chk("R3 rise stamp directed", {16'd0, d}, {16'd0, 16'(s2 + 16'd2)});
      bus_write(3'd3, 16'h0002);

      // R10 minimum level times
      drive_edge(1'b0, 4, s1);
      drive_edge(1'b1, 6, s2);
      bus_read(3'd0, d); chk("R10 short low fall stamp", {16'd0, d}, {16'd0, 16'(s1 + 16'd2)});
      bus_read(3'd1, d); chk("R10 short low rise stamp", {16'd0, d}, {16'd0, 16'(s2 + 16'd2)});
      bus_read(3'd3, d); chk("R10 flags no overrun", {16'd0, d}, 32'h3);
      bus_write(3'd3, 16'h001F);

      // R8 overrun on unread falling capture
      drive_edge(1'b0, 10, s1);
      drive_edge(1'b1, 10, s2);
      drive_edge(1'b0, 10, s3);
      bus_read(3'd3, d); chk("R8 fall overrun status", {16'd0, d}, 32'h0B);
      bus_read(3'd0, d); chk("R8 overwritten stamp", {16'd0, d}, {16'd0, 16'(s3 + 16'd2)});
      bus_write(3'd3, 16'h001F);
      bus_read(3'd3, d); chk("R6 all cleared", {16'd0, d}, 32'h0);
      drive_edge(1'b1, 10, s2);
      bus_read(3'd1, d);
      bus_read(3'd0, d);
      bus_write(3'd3, 16'h001F);
      bus_read(3'd3, d); chk("R8 no overrun after reads", {16'd0, d}, 32'h0);

      // R7 counter rollover with a capture straddling it
      bus_write(3'd2, 16'h0004);
      while (mcnt != 16'hFFFE) @(negedge clk);
      cap_in = 1'b0;
      @(negedge clk);
      #1 chk("R7 no wrap flag before rollover", {31'd0, irq}, 32'd0);
      @(negedge clk);
      #1 chk("R7 wrap irq after rollover", {31'd0, irq}, 32'd1);
      repeat (3) @(negedge clk);
      bus_read(3'd0, d); chk("R1 stamp wrapped to zero", {16'd0, d}, 32'h0);
      bus_read(3'd3, d); chk("R7 status wrap and fall", {16'd0, d}, 32'h5);
      bus_write(3'd3, 16'h0004);
      #1 chk("R6 wrap clear drops irq", {31'd0, irq}, 32'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule